// File: doc/BRIEF.md
# Serial Port Interrupt Prioritizer

This block forms the interrupt requests of a byte-oriented asynchronous serial port. It watches the receive-holding-full and transmit-holding-empty flags, three receive error flags, the receive line itself and the accesses that software makes to the port's data and status registers. From these it keeps four pending requests: a received byte that arrived with an error, a clean received byte, a transmit holding register that can take data, and a line that has gone idle.

Each request has an enable bit at a fixed position in a control word supplied by the surrounding port. The block drives one request line and a 2-bit code that names the most urgent request that is both pending and enabled. A request is removed by the register access that services it. The idle request is the exception: it is removed when the interrupt controller acknowledges it. The serial shifters, the bit-rate generator and the interrupt controller are outside this block.

Top module: `sio_irq_prio`

## Requirements
- R1: The request line `irq` is high whenever at least one request is pending and enabled. `irq_src` then names the winner in this order of urgency: 0 = receive with error (highest), 1 = receive, 2 = transmit empty, 3 = idle line (lowest).
- R2: The receive-with-error request becomes pending on the clock edge where `rx_full` is high, any bit of `err_flags` is high, and that combination was not present on the previous edge. It is enabled by `ctrl[16]`.
- R3: The receive-with-error request clears only when a `rxd_rd` pulse follows a `stat_rd` pulse that arrived while it was pending. A `rxd_rd` with no earlier status read leaves it pending.
- R4: The receive request becomes pending on a rising `rx_full`, is enabled by `ctrl[11]`, and clears on a `rxd_rd` pulse. While any bit of `err_flags` is high it is never presented.
- R5: The transmit request becomes pending on a rising `tx_empty`, is enabled by `ctrl[12]`, and clears on a `txd_wr` pulse even while `tx_empty` stays high.
- R6: The idle request, enabled by `ctrl[10]`, becomes pending on the `bit_tick` pulse that completes 10 consecutive high bit times on `rx_line` when `frame11` is 0, or 11 when `frame11` is 1.
- R7: The idle request stays latched until `ack` is pulsed while `irq_src` is 3 and `irq` is high. An `ack` while another source is presented leaves it pending.
- R8: After an idle detection, no further idle request is raised until `rx_line` has been seen low (a start bit). A low level also restarts the bit-time count.
- R9: During reset and right after it, with all inputs inactive, no request is pending and `irq` is low.
- R10: A pending request whose enable bit is 0 does not raise `irq` and does not affect `irq_src`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 24 | Control word holding the four enable bits |
| frame11 | input | 1 | 1 selects 11-bit frames (idle needs 11 bit times), 0 selects 10-bit frames |
| rx_full | input | 1 | Receive holding register full |
| err_flags | input | 3 | Parity, framing and overrun error flags of the held byte |
| tx_empty | input | 1 | Transmit holding register empty |
| rx_line | input | 1 | Synchronized receive line level |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| stat_rd | input | 1 | Status register read strobe |
| rxd_rd | input | 1 | Receive data register read strobe |
| txd_wr | input | 1 | Transmit data register write strobe |
| ack | input | 1 | Interrupt acknowledge from the controller |
| irq | output | 1 | Interrupt request |
| irq_src | output | 2 | Code of the presented source |

## Verification
The bench builds the block with its defaults: 24-bit control word, enables at positions 16, 11, 12 and 10, idle lengths of 10 and 11, and combinational outputs. With these values every one of the sixteen sets of pending requests can be built and checked against all sixteen enable patterns, and the expected code comes from a priority search written in the bench. The short idle lengths keep the threshold edges within a few cycles, so the bench tests one tick before the threshold and the tick on it in both frame modes. Directed sequences cover the order of the error-clear accesses, the missing re-arm and the acknowledge that targets another source.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
   typedef enum logic [1:0] {
      SRC_RXERR = 2'd0,
      SRC_RX    = 2'd1,
      SRC_TX    = 2'd2,
      SRC_IDLE  = 2'd3
   } sio_src_e;

   localparam int unsigned SIO_NSRC  = 4;
   localparam int unsigned SIO_SRC_W = 2;
endpackage

// File: rtl/sio_req_latch.sv
// Edge-set, strobe-cleared request bit. A new condition edge wins over
// a clear in the same cycle so no event is lost.
module sio_req_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   input  logic clr,
   output logic pend
);
   logic cond_q;
   logic set_evt;

   assign set_evt = cond & ~cond_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q <= 1'b0;
         pend   <= 1'b0;
      end else begin
         cond_q <= cond;
         if (set_evt)  pend <= 1'b1;
         else if (clr) pend <= 1'b0;
      end
   end
endmodule

// File: rtl/sio_idle_det.sv
// Counts high bit times on the receive line and latches one idle event
// per start bit.
module sio_idle_det #(
   parameter int unsigned IDLE_SHORT = 10,
   parameter int unsigned IDLE_LONG  = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_line,
   input  logic bit_tick,
   input  logic long_mode,
   input  logic ack_idle,
   output logic idle_pend
);
   localparam int unsigned CNT_W   = $clog2(IDLE_LONG + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (IDLE_SHORT < 1) begin : g_bad_short
      $error("IDLE_SHORT must be at least 1");
   end
   if (IDLE_LONG < IDLE_SHORT) begin : g_bad_long
      $error("IDLE_LONG must not be below IDLE_SHORT");
   end

   logic [CNT_W-1:0] hi_cnt;
   logic [CNT_W-1:0] limit;
   logic             armed;
   logic             hit;

   assign limit = long_mode ? CNT_W'(IDLE_LONG) : CNT_W'(IDLE_SHORT);
   assign hit   = armed & rx_line & bit_tick & (hi_cnt == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt    <= '0;
         armed     <= 1'b1;
         idle_pend <= 1'b0;
      end else begin
         if (!rx_line) begin
            hi_cnt <= '0;
            armed  <= 1'b1;
         end else if (bit_tick && hi_cnt != CNT_MAX) begin
            hi_cnt <= hi_cnt + 1'b1;
         end
         if (hit) begin
            armed     <= 1'b0;
            idle_pend <= 1'b1;
         end else if (ack_idle) begin
            idle_pend <= 1'b0;
         end
      end
   end

   assert_idle_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle_pend) |-> $past(ack_idle));
   assert_idle_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle_pend) |-> $past(rx_line) && $past(bit_tick));
endmodule

// File: rtl/sio_prio_enc.sv
// Fixed-priority encoder: lowest index wins.
module sio_prio_enc #(
   parameter int unsigned N = 4,
   localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
   import sio_irq_pkg::*;
#(
   parameter int unsigned CTRL_W     = 24,
   parameter int unsigned ERR_W      = 3,
   parameter int unsigned EN_RXERR   = 16,
   parameter int unsigned EN_RX      = 11,
   parameter int unsigned EN_TX      = 12,
   parameter int unsigned EN_IDLE    = 10,
   parameter int unsigned IDLE_SHORT = 10,
   parameter int unsigned IDLE_LONG  = 11,
   parameter bit          OUT_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] ctrl,
   input  logic              frame11,
   input  logic              rx_full,
   input  logic [ERR_W-1:0]  err_flags,
   input  logic              tx_empty,
   input  logic              rx_line,
   input  logic              bit_tick,
   input  logic              stat_rd,
   input  logic              rxd_rd,
   input  logic              txd_wr,
   input  logic              ack,
   output logic              irq,
   output logic [1:0]        irq_src
);
   if (EN_RXERR >= CTRL_W || EN_RX >= CTRL_W || EN_TX >= CTRL_W || EN_IDLE >= CTRL_W) begin : g_bad_pos
      $error("enable bit position outside the control word");
   end
   if (ERR_W < 1) begin : g_bad_err
      $error("ERR_W must be at least 1");
   end

   logic err_any;
   logic err_pend, rx_pend, tx_pend, idle_pend;
   logic stat_seen;
   logic err_clr;
   logic ack_idle;
   logic [SIO_NSRC-1:0] req;
   logic                any_c;
   logic [SIO_SRC_W-1:0] src_c;

   assign err_any = |err_flags;
   assign err_clr = rxd_rd & stat_seen;

   // status read arms the error clear; the following data read completes it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  stat_seen <= 1'b0;
      else if (!err_pend)          stat_seen <= 1'b0;
      else if (err_clr)            stat_seen <= 1'b0;
      else if (stat_rd)            stat_seen <= 1'b1;
   end

   sio_req_latch u_err (
      .clk(clk), .rst_n(rst_n), .cond(rx_full & err_any), .clr(err_clr), .pend(err_pend));
   sio_req_latch u_rx (
      .clk(clk), .rst_n(rst_n), .cond(rx_full), .clr(rxd_rd), .pend(rx_pend));
   sio_req_latch u_tx (
      .clk(clk), .rst_n(rst_n), .cond(tx_empty), .clr(txd_wr), .pend(tx_pend));

   sio_idle_det #(.IDLE_SHORT(IDLE_SHORT), .IDLE_LONG(IDLE_LONG)) u_idle (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_tick(bit_tick),
      .long_mode(frame11), .ack_idle(ack_idle), .idle_pend(idle_pend));

   assign req[SRC_RXERR] = err_pend  & ctrl[EN_RXERR];
   assign req[SRC_RX]    = rx_pend   & ctrl[EN_RX] & ~err_any;
   assign req[SRC_TX]    = tx_pend   & ctrl[EN_TX];
   assign req[SRC_IDLE]  = idle_pend & ctrl[EN_IDLE];

   sio_prio_enc #(.N(SIO_NSRC)) u_enc (.req(req), .any(any_c), .idx(src_c));

   assign ack_idle = ack & any_c & (src_c == SRC_IDLE);

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq     <= 1'b0;
            irq_src <= '0;
         end else begin
            irq     <= any_c;
            irq_src <= src_c;
         end
      end
   end else begin : g_out_comb
      assign irq     = any_c;
      assign irq_src = src_c;
   end

   assert_rx_below_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (any_c && src_c != SRC_RXERR) |-> !(err_pend && ctrl[EN_RXERR]));
   assert_err_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_pend) |-> $past(rxd_rd) && $past(stat_seen));
   assert_rx_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (any_c && src_c == SRC_RX) |-> !err_any);
   assert_tx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_pend) |-> $past(txd_wr));
   assert_enable_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (any_c && src_c == SRC_TX) |-> ctrl[EN_TX]);
endmodule

// File: tb/sio_irq_prio_tb.sv
module sio_irq_prio_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [23:0] ctrl;
   logic        frame11, rx_full, tx_empty, rx_line, bit_tick;
   logic [2:0]  err_flags;
   logic        stat_rd, rxd_rd, txd_wr, ack;
   logic        irq;
   logic [1:0]  irq_src;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   sio_irq_prio u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .frame11(frame11),
      .rx_full(rx_full), .err_flags(err_flags), .tx_empty(tx_empty),
      .rx_line(rx_line), .bit_tick(bit_tick), .stat_rd(stat_rd),
      .rxd_rd(rxd_rd), .txd_wr(txd_wr), .ack(ack),
      .irq(irq), .irq_src(irq_src));

   task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // irq and irq_src packed as {irq, src}; src only compared when irq is set
   task automatic chk_out(input logic e_irq, input logic [1:0] e_src, input string tag);
      chk({irq, (irq ? irq_src : 2'd0)}, {e_irq, (e_irq ? e_src : 2'd0)}, tag);
   endtask

   function automatic logic [23:0] mk_ctrl(input logic [3:0] e);
      logic [23:0] c = '0;
      c[16] = e[0]; c[11] = e[1]; c[12] = e[2]; c[10] = e[3];
      return c;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      ctrl = '0; frame11 = 1'b0; rx_full = 1'b0; err_flags = '0; tx_empty = 1'b0;
      rx_line = 1'b1; bit_tick = 1'b0; stat_rd = 1'b0; rxd_rd = 1'b0; txd_wr = 1'b0; ack = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic idle_cycle();
      @(negedge clk);
   endtask
   task automatic p_stat();  stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; endtask
   task automatic p_rxd();   rxd_rd  = 1'b1; @(negedge clk); rxd_rd  = 1'b0; endtask
   task automatic p_txw();   txd_wr  = 1'b1; @(negedge clk); txd_wr  = 1'b0; endtask
   task automatic p_ack();   ack     = 1'b1; @(negedge clk); ack     = 1'b0; endtask
   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0; @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic e_irq;
      logic [1:0] e_src;
      logic [3:0] eff;

      // R9: reset state
      rst_n = 1'b0;
      ctrl = 24'hFFFFFF; frame11 = 1'b0; rx_full = 1'b0; err_flags = '0; tx_empty = 1'b0;
      rx_line = 1'b1; bit_tick = 1'b0; stat_rd = 1'b0; rxd_rd = 1'b0; txd_wr = 1'b0; ack = 1'b0;
      @(negedge clk);
      chk_out(1'b0, 2'd0, "R9 in reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk_out(1'b0, 2'd0, "R9 after reset");

      // R1 R2 R4 R5 R6 R10: all pending sets against all enable patterns
      for (int s = 0; s < 16; s++) begin
         do_reset();
         if (s[0] || s[1]) begin
            rx_full = 1'b1;
            err_flags = s[0] ? (3'b001 << (s % 3)) : 3'b000;
            idle_cycle();
            if (s[0] && !s[1]) p_rxd();   // drops the plain receive, error stays (R3)
         end
         if (s[2]) begin
            tx_empty = 1'b1;
            idle_cycle();
         end
         if (s[3]) ticks(10);
         for (int e = 0; e < 16; e++) begin
            ctrl = mk_ctrl(e[3:0]);
            #1;
            eff[0] = s[0] & e[0];
            eff[1] = s[1] & e[1] & ~s[0];
            eff[2] = s[2] & e[2];
            eff[3] = s[3] & e[3];
            e_irq = |eff;
            e_src = 2'd0;
            for (int b = 3; b >= 0; b--) if (eff[b]) e_src = 2'(b);
            chk_out(e_irq, e_src, $sformatf("R1/R10 sweep s=%0d e=%0d", s, e));
         end
         @(negedge clk);
      end

      // R3: error clear needs status read then data read
      do_reset();
      ctrl = mk_ctrl(4'b1111);
      rx_full = 1'b1; err_flags = 3'b100;
      idle_cycle();
      chk_out(1'b1, 2'd0, "R2 error pending");
      p_rxd();
      chk_out(1'b1, 2'd0, "R3 data read alone keeps error");
      p_stat();
      chk_out(1'b1, 2'd0, "R3 status read alone keeps error");
      p_rxd();
      rx_full = 1'b0; err_flags = 3'b000;
      @(negedge clk);
      chk_out(1'b0, 2'd0, "R3 status then data clears");

      // R4: receive cleared by data read, masked by error flag
      rx_full = 1'b1; idle_cycle();
      chk_out(1'b1, 2'd1, "R4 receive pending");
      p_rxd();
      chk_out(1'b0, 2'd0, "R4 data read clears");
      rx_full = 1'b0; idle_cycle();
      rx_full = 1'b1; idle_cycle();
      ctrl = mk_ctrl(4'b0010);
      err_flags = 3'b010; idle_cycle();
      chk_out(1'b0, 2'd0, "R4 masked by error flag");
      err_flags = 3'b000; #1;
      chk_out(1'b1, 2'd1, "R4 unmasked when flag drops");

      // R5: transmit cleared by write while empty stays high
      do_reset();
      ctrl = mk_ctrl(4'b1111);
      tx_empty = 1'b1; idle_cycle();
      chk_out(1'b1, 2'd2, "R5 transmit pending");
      p_txw();
      chk_out(1'b0, 2'd0, "R5 write clears");

      // R6/R7/R8: idle lengths, ack, re-arm
      frame11 = 1'b1;
      ticks(10);
      chk_out(1'b0, 2'd0, "R6 11-bit mode after 10 ticks");
      ticks(1);
      chk_out(1'b1, 2'd3, "R6 11-bit mode after 11 ticks");
      p_ack();
      chk_out(1'b0, 2'd0, "R7 ack clears idle");
      ticks(12);
      chk_out(1'b0, 2'd0, "R8 no re-arm without start bit");
      rx_line = 1'b0; idle_cycle(); rx_line = 1'b1;
      frame11 = 1'b0;
      ticks(9);
      chk_out(1'b0, 2'd0, "R6 10-bit mode after 9 ticks");
      ticks(1);
      chk_out(1'b1, 2'd3, "R8 re-armed, R6 10 ticks");
      tx_empty = 1'b0; idle_cycle();
      tx_empty = 1'b1; idle_cycle();
      chk_out(1'b1, 2'd2, "R1 transmit above idle");
      p_ack();
      ctrl = mk_ctrl(4'b1000); #1;
      chk_out(1'b1, 2'd3, "R7 ack on other source keeps idle");
      ticks(3);
      rx_line = 1'b0; idle_cycle(); rx_line = 1'b1;
      ticks(4);
      rx_line = 1'b0; idle_cycle(); rx_line = 1'b1;
      p_ack();
      ticks(9);
      chk_out(1'b0, 2'd0, "R8 low level restarts count");
      ticks(1);
      chk_out(1'b1, 2'd3, "R8 count completes after restart");

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule